// File: doc/BRIEF.md
# Busy-Hold Status Register

This block sits between a host register bus and an internal FIFO engine. It gives the engine permission to run (busy) and tells the host, through a read-only status byte, whether the engine is busy or idle. The same byte also gathers the block's interrupt sources: a sticky flag for busy-to-idle transitions, three level flags (line-code change, timer elapsed, monitor bytes ready), and two ORs of masked interrupt requests.

The status byte can be read at two addresses. A read of the plain address has no side effects. A read of the hold address returns the same byte, but it also freezes the engine in idle until the host accesses any other address. Software reads the hold address until it shows idle. It can then touch FIFO or channel data registers without the engine going busy in the middle of that access. A port-select input gives a direct path to the hold register for hosts that use only two ports. A third address, the interrupt-status register, returns the byte and clears the transition flag.

Top module: `busy_hold_status`

## Requirements
- R1: Status byte fields:
  - bit0 is the busy permit (1 busy, 0 idle).
  - bit1 always reads 0.
  - bit3 follows `ichg_i`, bit4 follows `timer_i` and bit5 follows `mon_rdy_i`, as sampled in the read cycle.
- R2: A read of the plain status address (`STAT_ADDR`, port select 0) never clears any bit.
- R3: Bit2 (transition flag) is set at the same clock edge where the busy permit falls. It stays set until an interrupt-status read (`ISR_ADDR`, port select 0). After that read, later reads show bit2 at 0.
- R4: A read of the hold address (`HOLD_ADDR`) returns exactly the byte that the plain address returns for the same state and inputs.
- R5: A hold read sets the hold. From that read's clock edge on, the busy permit cannot rise, even when the busy request rises in the same cycle as the read.
- R6: A read with `port_sel_i`=1 is a hold read whatever the address. Any access (read or write) with `port_sel_i`=0 to an address other than `HOLD_ADDR` releases the hold.
- R7: A busy request that is pending under hold raises the busy permit at the clock edge of the releasing access.
- R8: The hold stays active across repeated hold reads and across a write to the hold address.
- R9: If an interrupt-status read and a new busy-to-idle transition happen in the same clock, bit2 stays set.
- R10: bit6 is the OR of `chan_irq_i & chan_mask_i`. bit7 is bit6 ORed with the masked misc flags:
  - `misc_mask_i[0]` masks bit2.
  - `misc_mask_i[1]` masks bit3.
  - `misc_mask_i[2]` masks bit4.
  - `misc_mask_i[3]` masks bit5.
- R11: Read data is registered. It appears one clock after the read strobe and holds until the next read. A read of any address that is not a status address returns 0x00. After reset `rdata_o` is 0x00.
- R12: The busy permit falls at the first clock edge after the busy request drops, whether or not the hold is active. After reset the permit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| port_sel_i | input | 1 | 1 selects the hold register directly |
| busy_req_i | input | 1 | Engine requests busy (level) |
| ichg_i | input | 1 | Line-code value change flag |
| timer_i | input | 1 | Timer elapsed flag |
| mon_rdy_i | input | 1 | Two monitor bytes received |
| chan_irq_i | input | N_CH | Data-channel interrupt requests |
| chan_mask_i | input | N_CH | Enables for chan_irq_i |
| misc_mask_i | input | 4 | Enables for status bits 2 to 5 in bit7 |
| rdata_o | output | 8 | Registered read data |
| busy_permit_o | output | 1 | Engine may run (busy state) |

## Verification
Both outputs are due one clock edge after the stimulus that causes them:
- Read data shows the byte for the state and inputs present in the read cycle.
- The busy permit follows the request at the edge after the request changes, or at the edge of a releasing access.

The bench drives every input on the falling edge and samples on the next falling edge. Each check therefore sees the result of exactly one rising edge. Hold blocking is checked over several idle cycles with the request held high. Release and simultaneous set-and-clear are checked at the single edge where they take effect.

// File: rtl/bhs_pkg.sv
package bhs_pkg;
  localparam int unsigned STAT_W = 8;

  typedef struct packed {
    logic hold_rd;
    logic other_acc;
    logic plain_rd;
    logic isr_rd;
  } bhs_dec_t;
endpackage

// File: rtl/bhs_decode.sv
module bhs_decode
  import bhs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] HOLD_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] ISR_ADDR  = 8'h12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              port_sel_i,
  output bhs_dec_t          dec_o
);
  logic is_hold;
  logic acc;

  assign is_hold = port_sel_i || (addr_i == HOLD_ADDR);
  assign acc     = rd_i || wr_i;

  always_comb begin
    dec_o.hold_rd   = rd_i && is_hold;
    dec_o.other_acc = acc && !is_hold;
    dec_o.plain_rd  = rd_i && !port_sel_i && (addr_i == STAT_ADDR);
    dec_o.isr_rd    = rd_i && !port_sel_i && (addr_i == ISR_ADDR);
  end
endmodule

// File: rtl/bhs_hold_gate.sv
module bhs_hold_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_rd_i,
  input  logic other_acc_i,
  input  logic busy_req_i,
  output logic hold_o,
  output logic busy_o,
  output logic fall_o
);
  logic hold_q, hold_d;
  logic busy_q, busy_d;

  // the hold blocks a rise already in the cycle of the hold read
  assign hold_d = hold_rd_i || (hold_q && !other_acc_i);
  assign busy_d = busy_q ? busy_req_i : (busy_req_i && !hold_d);
  assign fall_o = busy_q && !busy_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      busy_q <= busy_d;
    end
  end

  assign hold_o = hold_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/bhs_irq_agg.sv
module bhs_irq_agg
  import bhs_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              fall_i,
  input  logic              isr_rd_i,
  input  logic              ichg_i,
  input  logic              timer_i,
  input  logic              mon_rdy_i,
  input  logic [N_CH-1:0]   chan_irq_i,
  input  logic [N_CH-1:0]   chan_mask_i,
  input  logic [3:0]        misc_mask_i,
  output logic              flag_o,
  output logic [STAT_W-1:0] stat_o
);
  logic       flag_q;
  logic       chan_any;
  logic [3:0] misc_src;
  logic       misc_any;

  // new transition wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (fall_i)   flag_q <= 1'b1;
    else if (isr_rd_i) flag_q <= 1'b0;
  end

  assign chan_any = |(chan_irq_i & chan_mask_i);
  assign misc_src = {mon_rdy_i, timer_i, ichg_i, flag_q};
  assign misc_any = |(misc_src & misc_mask_i);

  assign stat_o = {chan_any || misc_any, chan_any, mon_rdy_i, timer_i,
                   ichg_i, flag_q, 1'b0, busy_i};
  assign flag_o = flag_q;
endmodule

// File: rtl/busy_hold_status.sv
module busy_hold_status
  import bhs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned N_CH      = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] HOLD_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] ISR_ADDR  = 8'h12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              port_sel_i,
  input  logic              busy_req_i,
  input  logic              ichg_i,
  input  logic              timer_i,
  input  logic              mon_rdy_i,
  input  logic [N_CH-1:0]   chan_irq_i,
  input  logic [N_CH-1:0]   chan_mask_i,
  input  logic [3:0]        misc_mask_i,
  output logic [7:0]        rdata_o,
  output logic              busy_permit_o
);
  bhs_dec_t          dec_s;
  logic              hold_s, busy_s, fall_s, flag_s;
  logic [STAT_W-1:0] stat_s;
  logic [7:0]        rdata_q;
  logic              stat_hit;

  bhs_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
    .HOLD_ADDR(HOLD_ADDR), .ISR_ADDR(ISR_ADDR)
  ) u_dec (
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .port_sel_i(port_sel_i), .dec_o(dec_s)
  );

  bhs_hold_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hold_rd_i(dec_s.hold_rd), .other_acc_i(dec_s.other_acc),
    .busy_req_i(busy_req_i),
    .hold_o(hold_s), .busy_o(busy_s), .fall_o(fall_s)
  );

  bhs_irq_agg #(.N_CH(N_CH)) u_agg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .busy_i(busy_s), .fall_i(fall_s), .isr_rd_i(dec_s.isr_rd),
    .ichg_i(ichg_i), .timer_i(timer_i), .mon_rdy_i(mon_rdy_i),
    .chan_irq_i(chan_irq_i), .chan_mask_i(chan_mask_i),
    .misc_mask_i(misc_mask_i),
    .flag_o(flag_s), .stat_o(stat_s)
  );

  assign stat_hit = dec_s.plain_rd || dec_s.hold_rd || dec_s.isr_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (stat_hit) rdata_q <= stat_s;
    else if (rd_i)     rdata_q <= '0;
  end

  assign rdata_o       = rdata_q;
  assign busy_permit_o = busy_s;
endmodule

// File: rtl/bhs_checker.sv
module bhs_checker #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              port_sel_i,
  input logic              busy_req_i,
  input logic              hold_i,
  input logic              other_acc_i,
  input logic              flag_i,
  input logic [7:0]        rdata_i,
  input logic              busy_permit_i
);
  AST_BIT1_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i[1] == 1'b0); // R1

  AST_PLAIN_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !port_sel_i && addr_i == STAT_ADDR && flag_i) |=> flag_i); // R2

  AST_FLAG_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_permit_i) |-> flag_i); // R3

  AST_NO_RISE_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !other_acc_i) |=> !$rose(busy_permit_i)); // R5

  AST_PORT_SEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && port_sel_i) |=> hold_i); // R6

  AST_GRANT_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && other_acc_i && busy_req_i) |=> busy_permit_i); // R7

  AST_FALL_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_permit_i && !busy_req_i) |=> !busy_permit_i); // R12
endmodule

bind busy_hold_status bhs_checker #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i),
  .port_sel_i(port_sel_i), .busy_req_i(busy_req_i), .hold_i(hold_s),
  .other_acc_i(dec_s.other_acc), .flag_i(flag_s), .rdata_i(rdata_o),
  .busy_permit_i(busy_permit_o)
);

// File: tb/busy_hold_status_test.sv
`timescale 1ns/1ps
module busy_hold_status_test;
  localparam logic [7:0] STAT = 8'h10, HOLD = 8'h11, ISR = 8'h12, FIFO = 8'h40;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0, psel = 1'b0, req = 1'b0;
  logic       ichg = 1'b0, tmr = 1'b0, mon = 1'b0;
  logic [3:0] chan = '0, cmask = '0, mmask = '0;
  logic [7:0] rdata;
  logic       permit;
  int         n_run = 0, n_fail = 0;
  logic [7:0] v, w;

  always #2 clk = ~clk;

  busy_hold_status uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .port_sel_i(psel), .busy_req_i(req), .ichg_i(ichg), .timer_i(tmr),
    .mon_rdy_i(mon), .chan_irq_i(chan), .chan_mask_i(cmask),
    .misc_mask_i(mmask), .rdata_o(rdata), .busy_permit_o(permit)
  );

  function automatic logic [7:0] model(logic b, logic f);
    logic c6;
    c6 = |(chan & cmask);
    return {c6 | (mmask[0] & f) | (mmask[1] & ichg) | (mmask[2] & tmr) | (mmask[3] & mon),
            c6, mon, tmr, ichg, f, 1'b0, b};
  endfunction

  task automatic chk(string req_id, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req_id, act, exp);
    end
  endtask

  task automatic do_rd(logic [7:0] a, logic p, output logic [7:0] d);
    @(negedge clk); addr = a; psel = p; rd = 1'b1;
    @(negedge clk); rd = 1'b0; psel = 1'b0; d = rdata;
  endtask

  task automatic do_wr(logic [7:0] a);
    @(negedge clk); addr = a; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_req(logic r);
    @(negedge clk); req = r;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 reset permit", {7'd0, permit}, 8'h00);
    chk("R11 reset rdata", rdata, 8'h00);
    do_rd(STAT, 1'b0, v);
    chk("R1 idle byte", v, 8'h00);
  endtask

  task automatic t_layout;
    ichg = 1; tmr = 1; mon = 0; chan = 4'b0101; cmask = 4'b0100; mmask = 4'b0000;
    do_rd(STAT, 1'b0, v);
    chk("R1 R10 layout a", v, model(1'b0, 1'b0));
    chk("R1 R10 literal a", v, 8'hD8);
    ichg = 1; tmr = 0; mon = 1; chan = 4'b0101; cmask = 4'b1010; mmask = 4'b0010;
    do_rd(STAT, 1'b0, v);
    chk("R1 R10 layout b", v, 8'hA8);
    mmask = 4'b0100;
    do_rd(STAT, 1'b0, v);
    chk("R10 masked misc", v, 8'h28);
    idle(3);
    chk("R11 rdata held", rdata, 8'h28);
    do_rd(8'h33, 1'b0, v);
    chk("R11 other addr zero", v, 8'h00);
    ichg = 0; tmr = 0; mon = 0; chan = '0; cmask = '0; mmask = '0;
  endtask

  task automatic t_flag;
    set_req(1'b1);
    chk("R12 permit rises", {7'd0, permit}, 8'h01);
    do_rd(STAT, 1'b0, v);
    chk("R1 busy bit", v, 8'h01);
    set_req(1'b0);
    chk("R12 permit falls", {7'd0, permit}, 8'h00);
    mmask = 4'b0001;
    do_rd(STAT, 1'b0, v);
    chk("R3 flag set", v, 8'h84);
    do_rd(STAT, 1'b0, v);
    chk("R2 plain no clear", v, 8'h84);
    do_rd(HOLD, 1'b0, w);
    chk("R4 alias equal", w, v);
    do_rd(ISR, 1'b0, v);
    chk("R3 isr returns flag", v, 8'h84);
    do_rd(STAT, 1'b0, v);
    chk("R3 flag cleared", v, 8'h00);
    mmask = '0;
  endtask

  task automatic t_hold;
    @(negedge clk); addr = HOLD; rd = 1'b1; req = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk("R5 same-cycle rise blocked", {7'd0, permit}, 8'h00);
    idle(4);
    chk("R5 still blocked", {7'd0, permit}, 8'h00);
    do_rd(HOLD, 1'b0, v);
    idle(2);
    chk("R8 repeat hold read", {7'd0, permit}, 8'h00);
    do_wr(HOLD);
    idle(2);
    chk("R8 write to hold addr", {7'd0, permit}, 8'h00);
    do_wr(FIFO);
    chk("R7 grant on release", {7'd0, permit}, 8'h01);
    set_req(1'b0);
    do_rd(ISR, 1'b0, v);
  endtask

  task automatic t_port;
    tmr = 1;
    do_rd(8'h5A, 1'b1, v);
    chk("R6 R4 port select read", v, 8'h10);
    set_req(1'b1);
    idle(3);
    chk("R6 port hold blocks", {7'd0, permit}, 8'h00);
    do_rd(8'h41, 1'b0, v);
    chk("R6 R7 release by port0", {7'd0, permit}, 8'h01);
    chk("R11 release read zero", v, 8'h00);
    tmr = 0;
  endtask

  task automatic t_fall_hold;
    do_rd(HOLD, 1'b0, v);
    chk("R1 busy under hold", v, 8'h01);
    set_req(1'b0);
    chk("R12 fall under hold", {7'd0, permit}, 8'h00);
    set_req(1'b1);
    idle(2);
    chk("R5 re-rise blocked", {7'd0, permit}, 8'h00);
    do_wr(FIFO);
    chk("R7 grant after release", {7'd0, permit}, 8'h01);
    do_rd(ISR, 1'b0, v);
  endtask

  task automatic t_set_clr;
    @(negedge clk); addr = ISR; rd = 1'b1; req = 1'b0;
    @(negedge clk); rd = 1'b0;
    chk("R9 isr snapshot", rdata, 8'h01);
    do_rd(STAT, 1'b0, v);
    chk("R9 set beats clear", v, 8'h04);
    do_rd(ISR, 1'b0, v);
    do_rd(STAT, 1'b0, v);
    chk("R3 cleared after", v, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    t_reset();
    t_layout();
    t_flag();
    t_hold();
    t_port();
    t_fall_hold();
    t_set_clr();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule